// File: doc/BRIEF.md
# Integer Execute Unit with Opcode Decode

This block is the integer execution stage of a simple 32-bit core. Each cycle it takes one instruction word and the two source operand values that the register file has already read for it. From the 6-bit major opcode it picks the operation and the form of the second operand. That operand is either the second register value or the 16-bit immediate, and the opcode sets how the immediate is widened: sign-extended, zero-extended, or placed in the upper half of the word. The block returns the result value, the index of the destination register and a write strobe for the register file.

The operations are addition, subtraction, the bitwise family (and, or, xor, nor, xnor), a multiply that keeps the low word, shifts in three flavours, and sign extension of a byte or a halfword. Comparisons put 0 or 1 into a general register; the block has no flag state. Writes to register 0 are dropped, so that register stays zero. Any opcode outside the supported set raises an illegal-instruction flag and writes nothing.

The datapath is combinational. A parameter chooses whether one output register follows it. By default the register is present: results appear one clock after the inputs, and reset clears them.

Top module: `exu_core`

## Requirements
- R1: The opcode is instr[31:26], the first source index is instr[25:21] and the second field is instr[20:16]. In the register form the destination is instr[15:11]. In the immediate form the immediate is instr[15:0] and the destination is instr[20:16].
- R2: The register-form opcodes take opb as the second operand and compute: 0x2D a+b, 0x32 a-b, 0x28 a AND b, 0x2E a OR b, 0x26 a XOR b, 0x21 NOT(a OR b), 0x29 NOT(a XOR b).
- R3: Immediate add 0x0D, immediate multiply 0x02 and the immediate compares 0x19, 0x1A, 0x1B and 0x1F sign-extend the 16-bit immediate to 32 bits.
- R4: Immediate and 0x08, or 0x0E, xor 0x06, nor 0x01 and xnor 0x09, and the unsigned immediate compares geu 0x1C and gtu 0x1D, zero-extend the immediate.
- R5: Opcode 0x18 computes a AND (imm<<16), and opcode 0x1E computes a OR (imm<<16).
- R6: Shift left (0x2F register, 0x0F immediate), arithmetic shift right (0x25, 0x05) and logical shift right (0x20, 0x00) use only the low 5 bits of the shift amount.
- R7: The register compares are eq 0x39, signed gt 0x3A, signed ge 0x3B, unsigned ge 0x3C, unsigned gt 0x3D and ne 0x3F. They and their immediate forms return exactly 0 or 1 in the destination.
- R8: Opcode 0x2C returns a with its low byte sign-extended, and 0x37 returns a with its low halfword sign-extended. Opcode 0x29 with opb equal to zero gives the bitwise NOT of a.
- R9: Multiply (0x22 register, 0x02 immediate) returns the low 32 bits of the product.
- R10: When the destination index is 0, wr_en is 0 while result and dest_idx still show the computed value and the index.
- R11: Any other opcode sets illegal to 1, wr_en to 0, result to 0 and dest_idx to 0.
- R12: With OUT_REG=1 (the default) all outputs update one clock after the inputs. While rst_n is low they hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset of the output register |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Value of the first source register |
| opb | input | 32 | Value of the second source register |
| result | output | 32 | Execution result |
| dest_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register-file write strobe |
| illegal | output | 1 | Unsupported opcode flag |

## Verification
The hardest cases to reach are the pairs of opcodes that share an operation and differ only in how the immediate is widened. A wrong widening shows only when the immediate's top bit is set and the other operand sits right at the boundary. The stimulus therefore uses immediates such as 0xFFFF and 0x8000 against operands of 0, 0x0000FFFF and 0xFFFF8000. For example, 0 compared with 0xFFFF gives opposite answers in the signed and unsigned greater-than forms. Shift amounts of 33 and 32 check that only the low five bits count.

// File: rtl/exu_pkg.sv
package exu_pkg;

   typedef enum logic [4:0] {
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR, OP_XNOR, OP_MUL,
      OP_SLL, OP_SRA, OP_SRL, OP_EQ, OP_NE, OP_GT, OP_GE, OP_GTU, OP_GEU,
      OP_SEXB, OP_SEXH
   } alu_op_e;

   // second-operand source
   typedef enum logic [1:0] {SRC_REG, SRC_SIMM, SRC_ZIMM, SRC_HIMM} src_e;

   typedef struct packed {
      logic    legal;
      alu_op_e op;
      src_e    src;
   } dec_t;

   function automatic dec_t mk_dec(alu_op_e o, src_e s);
      dec_t d;
      d.legal = 1'b1;
      d.op    = o;
      d.src   = s;
      return d;
   endfunction

endpackage

// File: rtl/exu_decode.sv
module exu_decode
   import exu_pkg::*;
#(
   parameter int OPC_W = 6
) (
   input  logic [OPC_W-1:0] opcode,
   output dec_t             dec
);

   always_comb begin
      dec = '{legal: 1'b0, op: OP_ADD, src: SRC_REG};
      case (opcode)
         // register forms
         6'h2D: dec = mk_dec(OP_ADD,  SRC_REG);
         6'h32: dec = mk_dec(OP_SUB,  SRC_REG);
         6'h28: dec = mk_dec(OP_AND,  SRC_REG);
         6'h2E: dec = mk_dec(OP_OR,   SRC_REG);
         6'h26: dec = mk_dec(OP_XOR,  SRC_REG);
         6'h21: dec = mk_dec(OP_NOR,  SRC_REG);
         6'h29: dec = mk_dec(OP_XNOR, SRC_REG);
         6'h22: dec = mk_dec(OP_MUL,  SRC_REG);
         6'h2F: dec = mk_dec(OP_SLL,  SRC_REG);
         6'h25: dec = mk_dec(OP_SRA,  SRC_REG);
         6'h20: dec = mk_dec(OP_SRL,  SRC_REG);
         6'h39: dec = mk_dec(OP_EQ,   SRC_REG);
         6'h3A: dec = mk_dec(OP_GT,   SRC_REG);
         6'h3B: dec = mk_dec(OP_GE,   SRC_REG);
         6'h3C: dec = mk_dec(OP_GEU,  SRC_REG);
         6'h3D: dec = mk_dec(OP_GTU,  SRC_REG);
         6'h3F: dec = mk_dec(OP_NE,   SRC_REG);
         6'h2C: dec = mk_dec(OP_SEXB, SRC_REG);
         6'h37: dec = mk_dec(OP_SEXH, SRC_REG);
         // immediate forms
         6'h0D: dec = mk_dec(OP_ADD,  SRC_SIMM);
         6'h02: dec = mk_dec(OP_MUL,  SRC_SIMM);
         6'h08: dec = mk_dec(OP_AND,  SRC_ZIMM);
         6'h0E: dec = mk_dec(OP_OR,   SRC_ZIMM);
         6'h06: dec = mk_dec(OP_XOR,  SRC_ZIMM);
         6'h01: dec = mk_dec(OP_NOR,  SRC_ZIMM);
         6'h09: dec = mk_dec(OP_XNOR, SRC_ZIMM);
         6'h0F: dec = mk_dec(OP_SLL,  SRC_ZIMM);
         6'h05: dec = mk_dec(OP_SRA,  SRC_ZIMM);
         6'h00: dec = mk_dec(OP_SRL,  SRC_ZIMM);
         6'h18: dec = mk_dec(OP_AND,  SRC_HIMM);
         6'h1E: dec = mk_dec(OP_OR,   SRC_HIMM);
         6'h19: dec = mk_dec(OP_EQ,   SRC_SIMM);
         6'h1A: dec = mk_dec(OP_GT,   SRC_SIMM);
         6'h1B: dec = mk_dec(OP_GE,   SRC_SIMM);
         6'h1F: dec = mk_dec(OP_NE,   SRC_SIMM);
         6'h1C: dec = mk_dec(OP_GEU,  SRC_ZIMM);
         6'h1D: dec = mk_dec(OP_GTU,  SRC_ZIMM);
         default: ;
      endcase
   end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
   import exu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] y
);

   localparam int SHAMT_W = $clog2(DATA_W);
   localparam int BYTE_W  = 8;
   localparam int HALF_W  = DATA_W / 2;

   logic [SHAMT_W-1:0] shamt;
   logic               cmp;
   logic               is_cmp;

   assign shamt = b[SHAMT_W-1:0];

   always_comb begin
      is_cmp = 1'b1;
      case (op)
         OP_EQ:   cmp = (a == b);
         OP_NE:   cmp = (a != b);
         OP_GT:   cmp = ($signed(a) >  $signed(b));
         OP_GE:   cmp = ($signed(a) >= $signed(b));
         OP_GTU:  cmp = (a >  b);
         OP_GEU:  cmp = (a >= b);
         default: begin cmp = 1'b0; is_cmp = 1'b0; end
      endcase
   end

   always_comb begin
      case (op)
         OP_ADD:  y = a + b;
         OP_SUB:  y = a - b;
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOR:  y = ~(a | b);
         OP_XNOR: y = ~(a ^ b);
         OP_MUL:  y = a * b;
         OP_SLL:  y = a << shamt;
         OP_SRA:  y = $unsigned($signed(a) >>> shamt);
         OP_SRL:  y = a >> shamt;
         OP_SEXB: y = {{(DATA_W-BYTE_W){a[BYTE_W-1]}}, a[BYTE_W-1:0]};
         OP_SEXH: y = {{(DATA_W-HALF_W){a[HALF_W-1]}}, a[HALF_W-1:0]};
         default: y = is_cmp ? {{(DATA_W-1){1'b0}}, cmp} : '0;
      endcase
   end

endmodule

// File: rtl/exu_stage.sv
module exu_stage #(
   parameter int W      = 8,
   parameter bit ENABLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (ENABLE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_wire
      assign q = d;
   end

endmodule

// File: rtl/exu_core.sv
module exu_core
   import exu_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int REG_IDX_W = 5,
   parameter int OPC_W     = 6,
   parameter int IMM_W     = 16,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DATA_W-1:0]    instr,
   input  logic [DATA_W-1:0]    opa,
   input  logic [DATA_W-1:0]    opb,
   output logic [DATA_W-1:0]    result,
   output logic [REG_IDX_W-1:0] dest_idx,
   output logic                 wr_en,
   output logic                 illegal
);

   localparam int OPC_LSB = DATA_W - OPC_W;
   localparam int RA_LSB  = OPC_LSB - REG_IDX_W;
   localparam int RB_LSB  = RA_LSB - REG_IDX_W;
   localparam int RD_LSB  = RB_LSB - REG_IDX_W;
   localparam int EXT_W   = DATA_W - IMM_W;
   localparam int BUS_W   = DATA_W + REG_IDX_W + 2;

   if (IMM_W > RB_LSB || RD_LSB < 0 || EXT_W < 1) begin : g_bad_geometry
      $error("exu_core: field widths do not fit the instruction word");
   end

   dec_t                 dec;
   logic [OPC_W-1:0]     opcode;
   logic [IMM_W-1:0]     imm;
   logic [DATA_W-1:0]    b_sel;
   logic [DATA_W-1:0]    alu_y;
   logic [REG_IDX_W-1:0] rd;
   logic [BUS_W-1:0]     bus_d;
   logic [BUS_W-1:0]     bus_q;
   logic                 ra_unused;

   assign opcode    = instr[DATA_W-1:OPC_LSB];
   assign imm       = instr[IMM_W-1:0];
   assign ra_unused = ^instr[OPC_LSB-1:RA_LSB];

   exu_decode #(.OPC_W(OPC_W)) i_decode (
      .opcode (opcode),
      .dec    (dec)
   );

   always_comb begin
      case (dec.src)
         SRC_SIMM: b_sel = {{EXT_W{imm[IMM_W-1]}}, imm};
         SRC_ZIMM: b_sel = {{EXT_W{1'b0}}, imm};
         SRC_HIMM: b_sel = {imm, {EXT_W{1'b0}}};
         default:  b_sel = opb;
      endcase
   end

   exu_alu #(.DATA_W(DATA_W)) i_alu (
      .op (dec.op),
      .a  (opa),
      .b  (b_sel),
      .y  (alu_y)
   );

   assign rd = (dec.src == SRC_REG) ? instr[RD_LSB +: REG_IDX_W]
                                    : instr[RB_LSB +: REG_IDX_W];

   always_comb begin
      if (dec.legal)
         bus_d = {alu_y, rd, (rd != '0), 1'b0};
      else
         bus_d = {{(DATA_W + REG_IDX_W + 1){1'b0}}, 1'b1};
   end

   exu_stage #(.W(BUS_W), .ENABLE(OUT_REG)) i_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_d),
      .q     (bus_q)
   );

   assign {result, dest_idx, wr_en, illegal} = bus_q;

endmodule

// File: rtl/exu_core_chk.sv
module exu_core_chk #(
   parameter int DATA_W    = 32,
   parameter int REG_IDX_W = 5,
   parameter int OPC_W     = 6,
   parameter int IMM_W     = 16,
   parameter bit OUT_REG   = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [DATA_W-1:0]    instr,
   input logic [DATA_W-1:0]    opa,
   input logic [DATA_W-1:0]    opb,
   input logic [DATA_W-1:0]    result,
   input logic [REG_IDX_W-1:0] dest_idx,
   input logic                 wr_en,
   input logic                 illegal
);

   localparam int EXT_W = DATA_W - IMM_W;
   localparam int RD_LSB = DATA_W - OPC_W - 3 * REG_IDX_W;

   logic [DATA_W-1:0] ins_q, a_q, b_q;

   // align the observed inputs with the output latency
   if (OUT_REG) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ins_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
         end else begin
            ins_q <= instr;
            a_q   <= opa;
            b_q   <= opb;
         end
      end
   end else begin : g_now
      assign ins_q = instr;
      assign a_q   = opa;
      assign b_q   = opb;
   end

   logic [OPC_W-1:0] opc_q;
   logic [IMM_W-1:0] imm_q;
   logic             cmp_q;
   assign opc_q = ins_q[DATA_W-1 -: OPC_W];
   assign imm_q = ins_q[IMM_W-1:0];
   assign cmp_q = opc_q inside {6'h39, 6'h3A, 6'h3B, 6'h3C, 6'h3D, 6'h3F,
                                6'h19, 6'h1A, 6'h1B, 6'h1C, 6'h1D, 6'h1F};

   assert_illegal_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (!wr_en && result == '0));

   assert_no_zero_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (dest_idx != '0));

   assert_bool_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_q |-> (result[DATA_W-1:1] == '0 && !illegal));

   assert_addi_sext_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (opc_q == 6'h0D) |-> (result == a_q + {{EXT_W{imm_q[IMM_W-1]}}, imm_q}));

   assert_reg_dest_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (opc_q == 6'h2D) |-> (dest_idx == ins_q[RD_LSB +: REG_IDX_W] && result == a_q + b_q));

endmodule

bind exu_core exu_core_chk #(
   .DATA_W(DATA_W), .REG_IDX_W(REG_IDX_W), .OPC_W(OPC_W),
   .IMM_W(IMM_W), .OUT_REG(OUT_REG)
) i_chk (
   .clk(clk), .rst_n(rst_n), .instr(instr), .opa(opa), .opb(opb),
   .result(result), .dest_idx(dest_idx), .wr_en(wr_en), .illegal(illegal)
);

// File: tb/test_exu_core.sv
module test_exu_core;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] instr = '0, opa = '0, opb = '0;
   logic [31:0] result;
   logic [4:0]  dest_idx;
   logic        wr_en, illegal;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exu_core i_exu_core (
      .clk(clk), .rst_n(rst_n), .instr(instr), .opa(opa), .opb(opb),
      .result(result), .dest_idx(dest_idx), .wr_en(wr_en), .illegal(illegal)
   );

   function automatic logic [31:0] rr(logic [5:0] op, logic [4:0] ra, logic [4:0] rb, logic [4:0] rd);
      return {op, ra, rb, rd, 11'b0};
   endfunction

   function automatic logic [31:0] ri(logic [5:0] op, logic [4:0] ra, logic [4:0] rd, logic [15:0] im);
      return {op, ra, rd, im};
   endfunction

   typedef struct packed {
      logic [31:0] ins;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] res;
      logic [4:0]  dst;
      logic        we;
      logic        ill;
      logic [3:0]  req;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{rr(6'h2D,1,2,3),  32'd5,        32'd7,        32'd12,       5'd3,  1'b1, 1'b0, 4'd2},  // R2 add
      '{rr(6'h32,1,2,4),  32'd5,        32'd7,        32'hFFFFFFFE, 5'd4,  1'b1, 1'b0, 4'd2},  // R2 sub
      '{rr(6'h21,1,2,5),  32'hF0F0F0F0, 32'h0F0F0000, 32'h00000F0F, 5'd5,  1'b1, 1'b0, 4'd2},  // R2 nor
      '{rr(6'h29,1,0,6),  32'h12345678, 32'h0,        32'hEDCBA987, 5'd6,  1'b1, 1'b0, 4'd8},  // R8 not
      '{ri(6'h0D,1,7,16'hFFFF), 32'h10, 32'h0,        32'h0000000F, 5'd7,  1'b1, 1'b0, 4'd3},  // R3 addi
      '{ri(6'h08,1,8,16'hFFFF), 32'hFFFFFFFF, 32'h0,  32'h0000FFFF, 5'd8,  1'b1, 1'b0, 4'd4},  // R4 andi
      '{ri(6'h18,1,9,16'h1234), 32'hFFFFFFFF, 32'h0,  32'h12340000, 5'd9,  1'b1, 1'b0, 4'd5},  // R5 and hi
      '{ri(6'h1E,1,10,16'hABCD), 32'h00001111, 32'h0, 32'hABCD1111, 5'd10, 1'b1, 1'b0, 4'd5},  // R5 or hi
      '{ri(6'h0F,1,11,16'h0021), 32'h1, 32'h0,        32'h2,        5'd11, 1'b1, 1'b0, 4'd6},  // R6 slli 33
      '{rr(6'h25,1,2,12), 32'h80000000, 32'h3F,       32'hFFFFFFFF, 5'd12, 1'b1, 1'b0, 4'd6},  // R6 sra
      '{rr(6'h20,1,2,13), 32'h80000000, 32'h1F,       32'h1,        5'd13, 1'b1, 1'b0, 4'd6},  // R6 srl
      '{rr(6'h3A,1,2,14), 32'hFFFFFFFF, 32'h1,        32'h0,        5'd14, 1'b1, 1'b0, 4'd7},  // R7 gt
      '{rr(6'h3D,1,2,15), 32'hFFFFFFFF, 32'h1,        32'h1,        5'd15, 1'b1, 1'b0, 4'd7},  // R7 gtu
      '{ri(6'h1A,1,16,16'hFFFF), 32'h0, 32'h0,        32'h1,        5'd16, 1'b1, 1'b0, 4'd3},  // R3 gti
      '{ri(6'h1D,1,17,16'hFFFF), 32'h0, 32'h0,        32'h0,        5'd17, 1'b1, 1'b0, 4'd4},  // R4 gtui
      '{ri(6'h1C,1,18,16'hFFFF), 32'h0000FFFF, 32'h0, 32'h1,        5'd18, 1'b1, 1'b0, 4'd4},  // R4 geui
      '{rr(6'h2C,1,0,19), 32'h00000080, 32'h0,        32'hFFFFFF80, 5'd19, 1'b1, 1'b0, 4'd8},  // R8 byte
      '{rr(6'h37,1,0,20), 32'h00017FFF, 32'h0,        32'h00007FFF, 5'd20, 1'b1, 1'b0, 4'd8},  // R8 half
      '{rr(6'h22,1,2,21), 32'h00010000, 32'h00010001, 32'h00010000, 5'd21, 1'b1, 1'b0, 4'd9},  // R9 mul
      '{ri(6'h02,1,22,16'hFFFE), 32'd3, 32'h0,        32'hFFFFFFFA, 5'd22, 1'b1, 1'b0, 4'd9},  // R9 muli
      '{rr(6'h2D,1,2,0),  32'd1,        32'd2,        32'd3,        5'd0,  1'b0, 1'b0, 4'd10}, // R10
      '{ri(6'h0D,1,0,16'h0005), 32'd1, 32'h0,         32'd6,        5'd0,  1'b0, 1'b0, 4'd10}, // R10
      '{ri(6'h04,1,5,16'h0010), 32'h55, 32'h66,       32'h0,        5'd0,  1'b0, 1'b1, 4'd11}, // R11
      '{ri(6'h11,3,4,16'h0020), 32'h77, 32'h77,       32'h0,        5'd0,  1'b0, 1'b1, 4'd11}, // R11
      '{rr(6'h39,1,2,23), 32'd5,        32'd5,        32'h1,        5'd23, 1'b1, 1'b0, 4'd7},  // R7 eq
      '{ri(6'h1F,1,24,16'h0005), 32'd5, 32'h0,        32'h0,        5'd24, 1'b1, 1'b0, 4'd7},  // R7 nei
      '{rr(6'h3B,1,2,25), 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h1,        5'd25, 1'b1, 1'b0, 4'd7},  // R7 ge
      '{ri(6'h1B,1,26,16'h8000), 32'hFFFF8000, 32'h0, 32'h1,        5'd26, 1'b1, 1'b0, 4'd3},  // R3 gei
      '{ri(6'h05,1,27,16'h0004), 32'hF0000000, 32'h0, 32'hFF000000, 5'd27, 1'b1, 1'b0, 4'd6},  // R6 srai
      '{ri(6'h00,1,28,16'h0004), 32'hF0000000, 32'h0, 32'h0F000000, 5'd28, 1'b1, 1'b0, 4'd6},  // R6 srli
      '{rr(6'h26,1,2,1),  32'hFF00FF00, 32'h0FF00FF0, 32'hF0F0F0F0, 5'd1,  1'b1, 1'b0, 4'd2},  // R2 xor
      '{rr(6'h28,1,2,2),  32'hFF00FF00, 32'h0FF00FF0, 32'h0F000F00, 5'd2,  1'b1, 1'b0, 4'd2},  // R2 and
      '{ri(6'h06,1,29,16'hFFFF), 32'hFFFF0000, 32'h0, 32'hFFFFFFFF, 5'd29, 1'b1, 1'b0, 4'd4},  // R4 xori
      '{ri(6'h09,1,30,16'h00FF), 32'h0, 32'h0,        32'hFFFFFF00, 5'd30, 1'b1, 1'b0, 4'd4},  // R4 xnori
      '{ri(6'h01,1,31,16'h0001), 32'h0, 32'h0,        32'hFFFFFFFE, 5'd31, 1'b1, 1'b0, 4'd4},  // R4 nori
      '{rr(6'h3C,1,2,3),  32'h1,        32'hFFFFFFFF, 32'h0,        5'd3,  1'b1, 1'b0, 4'd7},  // R7 geu
      '{rr(6'h3F,1,2,4),  32'h1,        32'h2,        32'h1,        5'd4,  1'b1, 1'b0, 4'd7},  // R7 ne
      '{rr(6'h2F,1,2,5),  32'h1,        32'h20,       32'h1,        5'd5,  1'b1, 1'b0, 4'd6},  // R6 sll 32
      '{rr(6'h2E,1,2,6),  32'h0F,       32'hF0,       32'hFF,       5'd6,  1'b1, 1'b0, 4'd2},  // R2 or
      '{ri(6'h0E,1,3,16'h8000), 32'h1, 32'h0,         32'h00008001, 5'd3,  1'b1, 1'b0, 4'd4}   // R4 ori
   };

   task automatic check_out(string tag, logic [31:0] er, logic [4:0] ed, logic ew, logic ei);
      checks++;
      if (result !== er || dest_idx !== ed || wr_en !== ew || illegal !== ei) begin
         errors++;
         $display("FAIL %s: got res=%h dst=%0d we=%b ill=%b exp res=%h dst=%0d we=%b ill=%b",
                  tag, result, dest_idx, wr_en, illegal, er, ed, ew, ei);
      end
   endtask

   initial begin
      // R12 reset: outputs zero while held in reset with a live instruction
      instr = rr(6'h2D, 1, 2, 3);
      opa   = 32'd9;
      opb   = 32'd9;
      repeat (3) @(negedge clk);
      check_out("R12 reset", 32'h0, 5'd0, 1'b0, 1'b0);
      rst_n = 1'b1;
      instr = '0;
      opa   = '0;
      opb   = '0;
      @(negedge clk);
      // srl by 0 of zero into r0: result 0, no write
      check_out("R12 after reset", 32'h0, 5'd0, 1'b0, 1'b0);

      // R12 latency: value appears only after the next rising edge
      instr = rr(6'h2D, 1, 2, 9);
      opa   = 32'd40;
      opb   = 32'd2;
      #(CLK_PERIOD/4);
      check_out("R12 before edge", 32'h0, 5'd0, 1'b0, 1'b0);
      @(negedge clk);
      check_out("R12 after edge", 32'd42, 5'd9, 1'b1, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         instr = VECS[i].ins;
         opa   = VECS[i].a;
         opb   = VECS[i].b;
         @(negedge clk);
         check_out($sformatf("R%0d vec %0d", VECS[i].req, i),
                   VECS[i].res, VECS[i].dst, VECS[i].we, VECS[i].ill);
      end

      // R1: immediate form ignores opb and writes field [20:16]
      instr = ri(6'h0D, 5'd7, 5'd17, 16'h0100);
      opa   = 32'h1000;
      opb   = 32'hDEADBEEF;
      @(negedge clk);
      check_out("R1 imm dest", 32'h1100, 5'd17, 1'b1, 1'b0);

      // R1: register form writes field [15:11], not [20:16]
      instr = rr(6'h32, 5'd4, 5'd12, 5'd27);
      opa   = 32'd100;
      opb   = 32'd1;
      @(negedge clk);
      check_out("R1 reg dest", 32'd99, 5'd27, 1'b1, 1'b0);

      // R11: top unused opcode 0x3E
      instr = {6'h3E, 26'h3FFFFFF};
      @(negedge clk);
      check_out("R11 opcode 0x3E", 32'h0, 5'd0, 1'b0, 1'b1);

      // R12: reset asserted mid-run clears registered outputs
      instr = rr(6'h2D, 1, 2, 3);
      opa   = 32'd1;
      opb   = 32'd1;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_out("R12 async reset", 32'h0, 5'd0, 1'b0, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule